// File: doc/BRIEF.md
# DRAM Self-Refresh Exit Sequencer

This block brings one DRAM channel back out of self-refresh and tells the command scheduler which kinds of command it may send at each step. An exit request starts the sequence. First the channel stays silent for the exit-to-first-command delay. That delay is the refresh execution time plus a small programmed offset. Next the block fires a one-cycle long-ZQ-calibration strobe and waits for the programmed calibration time. Non-data commands are then released. Reads and writes stay blocked until the DLL-relock delay has run out. That delay is counted from the exit request, and it runs in parallel with the earlier steps.

Independently of the exit sequence, every mode-register-set command that the controller issues closes all permits for a fixed base of 8 cycles plus a programmed gap. A request to enter self-refresh is accepted once the channel is fully released, and it returns the block to its idle state. Configuration inputs are sampled when they are used. They are expected to be quasi-static.

Top module: `sr_exit_seq`

## Requirements
- R1: After reset the block is in self-refresh: `permit_cmd`, `permit_rdwr` and `zqcl_strobe` are all 0.
- R2: An `exit_req` sampled at clock edge E0 while in self-refresh keeps both permits low during cycles E0 to E0+tXS-1. `zqcl_strobe` is then high for exactly the one cycle that begins at edge E0+tXS. Here tXS = `cfg_trfc` + the effective offset.
- R3: The effective offset is `cfg_xs_ofs` limited to the range 3 to 11: a value below 3 acts as 3, and a value above 11 acts as 11.
- R4: The calibration phase starts with the strobe and lasts max(`cfg_zq_cycles`, 1) cycles. No permit is granted during it.
- R5: After calibration, `permit_cmd` is 1 and `permit_rdwr` is 0 until cycle E0+`cfg_dll_cycles`. From then on both are 1.
- R6: If `cfg_dll_cycles` ≤ tXS + calibration length, both permits rise together in the first cycle after calibration.
- R7: An `mrs_issue` sampled at edge M forces both permits to 0 during cycles M to M+7+`cfg_mrs_gap`, in any phase. A new `mrs_issue` restarts the window from its own edge.
- R8: `exit_req` has no effect outside self-refresh, and `sr_enter` has no effect outside the fully released phase. An `sr_enter` in that phase returns the block to self-refresh, with both permits 0 from the next cycle.
- R9: `permit_rdwr` is never 1 while `permit_cmd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exit_req | input | 1 | One-cycle request to leave self-refresh |
| sr_enter | input | 1 | One-cycle notice that the channel entered self-refresh |
| mrs_issue | input | 1 | One-cycle notice that a mode-register-set was issued |
| cfg_trfc | input | 9 | Refresh execution time in cycles |
| cfg_xs_ofs | input | 4 | Exit offset added to the refresh time (clamped to 3..11) |
| cfg_zq_cycles | input | 10 | Long calibration time in cycles |
| cfg_dll_cycles | input | 12 | Exit-to-data delay in cycles |
| cfg_mrs_gap | input | 4 | Extra mode-register-set spacing above the base of 8 |
| permit_cmd | output | 1 | Non-data commands may be issued |
| permit_rdwr | output | 1 | Read and write commands may be issued |
| zqcl_strobe | output | 1 | One-cycle pulse: issue the long ZQ calibration now |

## Verification
The bench builds the block with its default field widths: a 9-bit refresh time, a 4-bit offset and gap, a 10-bit calibration count and a 12-bit data delay. It then programs small refresh and delay values, so that a full exit sequence lasts tens of cycles. With these values every phase boundary can be compared cycle by cycle.

The chosen settings put the data delay after calibration ends, exactly at its end, and well before it. They drive the offset to 0 and to 15, to reach both clamp limits. They use a calibration value of 0, and the smallest and largest mode-register-set gaps, including a restart inside an open window.

// File: rtl/sr_exit_pkg.sv
// Package: shared phase encoding for the self-refresh exit sequencer.
// Assumes: consumers only compare against the named values.
package sr_exit_pkg;

    typedef enum logic [2:0] {
        PH_IN_SR    = 3'd0,
        PH_WAIT_XS  = 3'd1,
        PH_ZQCL     = 3'd2,
        PH_WAIT_DLL = 3'd3,
        PH_READY    = 3'd4
    } sr_phase_e;

endpackage

// File: rtl/sr_down_timer.sv
// Module: loadable down-counter used for every delay in the sequencer.
// Loading value L makes busy high for exactly L cycles after the load edge;
// last flags the final busy cycle. A load wins over counting.
// Assumes: load_val is meaningful only in the cycle load is high.
module sr_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         last
);

    logic [W-1:0] cnt_q;

    // count register: reload on request, otherwise drain towards zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // status decode
    always_comb begin
        busy = (cnt_q != '0);
        last = (cnt_q == W'(1));
    end

    // once in its final cycle with no reload, the timer must be idle next
    assert_timer_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> !busy);

endmodule

// File: rtl/sr_exit_fsm.sv
// Module: phase machine for the self-refresh exit.
// Moves IN_SR -> WAIT_XS -> ZQCL -> (WAIT_DLL) -> READY and back to IN_SR on
// sr_enter. It issues the timer loads and a registered one-cycle ZQ strobe.
// Assumes: the ZQ timer is loaded with at least 1, and tXS is at least 3.
module sr_exit_fsm
    import sr_exit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      exit_req,
    input  logic      sr_enter,
    input  logic      xs_busy,
    input  logic      xs_last,
    input  logic      zq_busy,
    input  logic      zq_last,
    input  logic      dll_busy,
    input  logic      dll_last,
    output sr_phase_e phase_q,
    output logic      xs_load,
    output logic      zq_load,
    output logic      dll_load,
    output logic      zq_strobe_q
);

    sr_phase_e phase_d;
    logic      dll_done_next;

    // the data delay counter will read zero after the coming edge
    always_comb dll_done_next = !dll_busy || dll_last;

    // next-phase and timer-load decode
    always_comb begin
        phase_d  = phase_q;
        xs_load  = 1'b0;
        zq_load  = 1'b0;
        dll_load = 1'b0;
        unique case (phase_q)
            PH_IN_SR: begin
                if (exit_req) begin
                    phase_d  = PH_WAIT_XS;
                    xs_load  = 1'b1;
                    dll_load = 1'b1;
                end
            end
            PH_WAIT_XS: begin
                if (xs_last) begin
                    phase_d = PH_ZQCL;
                    zq_load = 1'b1;
                end
            end
            PH_ZQCL: begin
                if (zq_last) begin
                    phase_d = dll_done_next ? PH_READY : PH_WAIT_DLL;
                end
            end
            PH_WAIT_DLL: begin
                if (dll_done_next) begin
                    phase_d = PH_READY;
                end
            end
            PH_READY: begin
                if (sr_enter) begin
                    phase_d = PH_IN_SR;
                end
            end
            default: phase_d = PH_IN_SR;
        endcase
    end

    // phase register and strobe on entry to calibration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IN_SR;
            zq_strobe_q <= 1'b0;
        end else begin
            phase_q     <= phase_d;
            zq_strobe_q <= (phase_q != PH_ZQCL) && (phase_d == PH_ZQCL);
        end
    end

    assert_sr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IN_SR && !exit_req) |=> phase_q == PH_IN_SR);

    assert_xs_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WAIT_XS) |-> xs_busy);

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        zq_strobe_q |=> !zq_strobe_q);

    assert_strobe_in_zq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zq_strobe_q |-> (phase_q == PH_ZQCL && zq_busy));

    assert_ready_after_dll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_READY) |-> !dll_busy);

endmodule

// File: rtl/sr_permit_gate.sv
// Module: turns the exit phase and the MRS spacing window into the per-class
// command permits. Purely combinational.
// Assumes: phase and mrs_busy come straight from registers.
module sr_permit_gate
    import sr_exit_pkg::*;
(
    input  sr_phase_e phase,
    input  logic      mrs_busy,
    output logic      permit_cmd,
    output logic      permit_rdwr
);

    logic phase_cmd;
    logic phase_rdwr;

    // per-phase permission, before the MRS window is applied
    always_comb begin
        phase_cmd  = (phase == PH_WAIT_DLL) || (phase == PH_READY);
        phase_rdwr = (phase == PH_READY);
    end

    // an open MRS window overrides every class
    always_comb begin
        permit_cmd  = phase_cmd  && !mrs_busy;
        permit_rdwr = phase_rdwr && !mrs_busy;
    end

endmodule

// File: rtl/sr_exit_seq.sv
// Module: top of the self-refresh exit sequencer.
// Builds tXS from the refresh time plus the clamped offset, and the MRS
// spacing from a base plus the programmed gap. It runs the data delay timer
// from the exit request, alongside the phase machine.
// Assumes: the configuration inputs are stable around their sampling edges.
module sr_exit_seq
    import sr_exit_pkg::*;
#(
    parameter int TRFC_W   = 9,
    parameter int OFS_W    = 4,
    parameter int OFS_MIN  = 3,
    parameter int OFS_MAX  = 11,
    parameter int ZQ_W     = 10,
    parameter int DLL_W    = 12,
    parameter int MOD_W    = 4,
    parameter int MOD_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exit_req,
    input  logic              sr_enter,
    input  logic              mrs_issue,
    input  logic [TRFC_W-1:0] cfg_trfc,
    input  logic [OFS_W-1:0]  cfg_xs_ofs,
    input  logic [ZQ_W-1:0]   cfg_zq_cycles,
    input  logic [DLL_W-1:0]  cfg_dll_cycles,
    input  logic [MOD_W-1:0]  cfg_mrs_gap,
    output logic              permit_cmd,
    output logic              permit_rdwr,
    output logic              zqcl_strobe
);

    localparam int XS_W    = ((TRFC_W > OFS_W) ? TRFC_W : OFS_W) + 1;
    localparam int MRS_MAX = MOD_BASE + (1 << MOD_W) - 1;
    localparam int MRS_W   = $clog2(MRS_MAX + 1);

    sr_phase_e          phase;
    logic [OFS_W-1:0]   ofs_eff;
    logic [XS_W-1:0]    xs_val;
    logic [ZQ_W-1:0]    zq_val;
    logic [MRS_W-1:0]   mrs_val;
    logic xs_load, zq_load, dll_load;
    logic xs_busy, xs_last, zq_busy, zq_last, dll_busy, dll_last;
    logic mrs_busy, mrs_last;

    // offset clamp and delay arithmetic
    always_comb begin
        if (cfg_xs_ofs < OFS_W'(OFS_MIN)) begin
            ofs_eff = OFS_W'(OFS_MIN);
        end else if (cfg_xs_ofs > OFS_W'(OFS_MAX)) begin
            ofs_eff = OFS_W'(OFS_MAX);
        end else begin
            ofs_eff = cfg_xs_ofs;
        end
        xs_val  = XS_W'(cfg_trfc) + XS_W'(ofs_eff);
        zq_val  = (cfg_zq_cycles == '0) ? ZQ_W'(1) : cfg_zq_cycles;
        mrs_val = MRS_W'(MOD_BASE) + MRS_W'(cfg_mrs_gap);
    end

    sr_down_timer #(.W(XS_W)) u_xs_timer (
        .clk(clk), .rst_n(rst_n), .load(xs_load), .load_val(xs_val),
        .busy(xs_busy), .last(xs_last)
    );

    sr_down_timer #(.W(ZQ_W)) u_zq_timer (
        .clk(clk), .rst_n(rst_n), .load(zq_load), .load_val(zq_val),
        .busy(zq_busy), .last(zq_last)
    );

    sr_down_timer #(.W(DLL_W)) u_dll_timer (
        .clk(clk), .rst_n(rst_n), .load(dll_load), .load_val(cfg_dll_cycles),
        .busy(dll_busy), .last(dll_last)
    );

    sr_down_timer #(.W(MRS_W)) u_mrs_timer (
        .clk(clk), .rst_n(rst_n), .load(mrs_issue), .load_val(mrs_val),
        .busy(mrs_busy), .last(mrs_last)
    );

    sr_exit_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .exit_req(exit_req), .sr_enter(sr_enter),
        .xs_busy(xs_busy), .xs_last(xs_last), .zq_busy(zq_busy), .zq_last(zq_last),
        .dll_busy(dll_busy), .dll_last(dll_last), .phase_q(phase),
        .xs_load(xs_load), .zq_load(zq_load), .dll_load(dll_load),
        .zq_strobe_q(zqcl_strobe)
    );

    sr_permit_gate u_gate (
        .phase(phase), .mrs_busy(mrs_busy),
        .permit_cmd(permit_cmd), .permit_rdwr(permit_rdwr)
    );

    assert_mrs_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_issue |=> (!permit_cmd && !permit_rdwr));

    assert_mrs_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_last && !mrs_issue && phase == PH_READY && !sr_enter) |=> permit_rdwr);

    assert_data_implies_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        permit_rdwr |-> permit_cmd);

    assert_no_permit_in_zq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zqcl_strobe |-> !permit_cmd);

endmodule

// File: tb/sr_exit_seq_bench.sv
// Bench: time-stamp reference model of the exit sequence, compared each cycle.
module sr_exit_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exit_req = 1'b0;
    logic        sr_enter = 1'b0;
    logic        mrs_issue = 1'b0;
    logic [8:0]  cfg_trfc = 9'd10;
    logic [3:0]  cfg_xs_ofs = 4'd5;
    logic [9:0]  cfg_zq_cycles = 10'd6;
    logic [11:0] cfg_dll_cycles = 12'd60;
    logic [3:0]  cfg_mrs_gap = 4'd0;
    logic        permit_cmd, permit_rdwr, zqcl_strobe;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;
    string scen = "R1";

    // model state: absolute cycle stamps
    int cyc = 0;
    bit m_in_sr = 1'b1;
    int m_exit = 0, m_txs = 0, m_zq = 0, m_rdy = 0, m_mrs_end = -1;

    always #5 clk = ~clk;

    sr_exit_seq u_sr_exit_seq (
        .clk(clk), .rst_n(rst_n), .exit_req(exit_req), .sr_enter(sr_enter),
        .mrs_issue(mrs_issue), .cfg_trfc(cfg_trfc), .cfg_xs_ofs(cfg_xs_ofs),
        .cfg_zq_cycles(cfg_zq_cycles), .cfg_dll_cycles(cfg_dll_cycles),
        .cfg_mrs_gap(cfg_mrs_gap), .permit_cmd(permit_cmd),
        .permit_rdwr(permit_rdwr), .zqcl_strobe(zqcl_strobe)
    );

    // 0 sr, 1 wait xs, 2 zq, 3 wait dll, 4 ready
    function automatic int phase_at(int c);
        int d;
        if (m_in_sr) return 0;
        d = c - m_exit;
        if (d < m_txs) return 1;
        if (d < m_txs + m_zq) return 2;
        if (c < m_rdy) return 3;
        return 4;
    endfunction

    always @(posedge clk) begin
        int ph, ofs, zq, dll, late;
        if (!rst_n) begin
            m_in_sr = 1'b1;
            m_mrs_end = -1;
        end else begin
            ph = phase_at(cyc);
            if (ph == 0 && exit_req) begin
                ofs = int'(cfg_xs_ofs);
                if (ofs < 3) ofs = 3;
                if (ofs > 11) ofs = 11;
                zq = (cfg_zq_cycles == 0) ? 1 : int'(cfg_zq_cycles);
                dll = int'(cfg_dll_cycles);
                m_in_sr = 1'b0;
                m_exit = cyc + 1;
                m_txs = int'(cfg_trfc) + ofs;
                m_zq = zq;
                late = (dll > m_txs + zq) ? dll : m_txs + zq;
                m_rdy = m_exit + late;
            end else if (ph == 4 && sr_enter) begin
                m_in_sr = 1'b1;
            end
            if (mrs_issue) m_mrs_end = cyc + 1 + 8 + int'(cfg_mrs_gap);
        end
        cyc = cyc + 1;
    end

    task automatic compare();
        int ph;
        bit mb, e_cmd, e_rd, e_stb;
        string ptag;
        ph = phase_at(cyc);
        mb = (cyc < m_mrs_end);
        e_cmd = (ph >= 3) && !mb;
        e_rd = (ph == 4) && !mb;
        e_stb = (ph == 2) && (cyc == m_exit + m_txs);
        case (ph)
            0: ptag = "R8";
            1: ptag = "R2";
            2: ptag = "R4";
            3: ptag = "R5";
            default: ptag = "R6";
        endcase
        if (mb) ptag = "R7";
        checks++;
        if ({permit_cmd, permit_rdwr, zqcl_strobe} != {e_cmd, e_rd, e_stb}) begin
            bad++;
            $display("FAIL %s/%s cyc=%0d actual cmd/rdwr/stb=%b%b%b expected=%b%b%b",
                     scen, ptag, cyc, permit_cmd, permit_rdwr, zqcl_strobe,
                     e_cmd, e_rd, e_stb);
        end
        checks++;
        if (permit_rdwr && !permit_cmd) begin   // R9
            bad++;
            $display("FAIL R9 cyc=%0d actual rdwr=1 cmd=0 expected rdwr<=cmd", cyc);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) compare();
            exit_req = 1'b0;
            sr_enter = 1'b0;
            mrs_issue = 1'b0;
        end
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        scen = "R1";
        step(4);

        // long data delay: WAIT_DLL visible; stray inputs ignored
        scen = "R5";
        exit_req = 1'b1; step(1);
        scen = "R8"; sr_enter = 1'b1; step(3);
        exit_req = 1'b1; step(1);
        scen = "R2"; step(25);
        scen = "R7"; cfg_mrs_gap = 4'd0; mrs_issue = 1'b1; step(15);
        scen = "R5"; step(30);
        scen = "R8"; sr_enter = 1'b1; step(5);

        // offset below range, data delay ahead of calibration
        scen = "R3"; cfg_trfc = 9'd4; cfg_xs_ofs = 4'd0; cfg_zq_cycles = 10'd4;
        cfg_dll_cycles = 12'd8;
        exit_req = 1'b1; step(1);
        scen = "R6"; step(19);
        scen = "R7"; cfg_mrs_gap = 4'd15; mrs_issue = 1'b1; step(5);
        mrs_issue = 1'b1; step(28);
        sr_enter = 1'b1; step(3);

        // offset above range, zero calibration value
        scen = "R3"; cfg_trfc = 9'd5; cfg_xs_ofs = 4'd15; cfg_zq_cycles = 10'd0;
        cfg_dll_cycles = 12'd16;
        exit_req = 1'b1; step(25);
        sr_enter = 1'b1; step(2);
        scen = "R7"; cfg_mrs_gap = 4'd3; mrs_issue = 1'b1; step(14);

        // data delay ending exactly with calibration; MRS across the edge
        scen = "R6"; cfg_trfc = 9'd3; cfg_xs_ofs = 4'd3; cfg_zq_cycles = 10'd5;
        cfg_dll_cycles = 12'd11;
        exit_req = 1'b1; step(4);
        scen = "R7"; cfg_mrs_gap = 4'd1; mrs_issue = 1'b1; step(20);
        scen = "R6"; step(5);

        // reset mid-sequence returns to self-refresh
        scen = "R1"; exit_req = 1'b1; step(5);
        rst_n = 1'b0; step(2);
        rst_n = 1'b1; step(4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule